// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a bank of digital inputs and raises a single level-sensitive interrupt when a configured change-of-state condition occurs on its low sixteen channels. Every input first crosses into the clock domain through a two-flop synchroniser. Edges are found by comparing each synchronised sample with the one taken a cycle earlier.

Two per-channel arming masks select what each channel watches. The high mask selects a rising edge or a high level. The low mask selects a falling edge or a low level. A global combining mode gives two behaviours. In edge mode, any armed channel that sees its edge raises the interrupt. In level mode, the interrupt is raised only when all armed channels hold their selected levels at the same time. After a level-mode event the logic stays latched until one of the armed inputs changes.

A small 32-bit register bus with read and write strobes configures the block. A status register holds the channel pattern that caused the event, and reading it clears the pending state.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the control, high-mask, low-mask and status registers read as zero and irq is low.
- R2: The register word offsets are 0x00 for the synchronised input (read only), 0x04 for the high mask, 0x08 for the low mask, 0x0C for the status (read clears) and 0x10 for the control. The masks read back their low 16 bits, and the upper bits read as zero. The input reading follows a pin change after two clock edges.
- R3: With control = 2'b01 (bit 0 is enable, bit 1 selects level mode when set), a rising edge on a channel set in the high mask, or a falling edge on a channel set in the low mask, sets the pending state and ORs that channel into status. An edge of the other direction, or an edge on an unarmed channel, does nothing.
- R4: Input channels 16 and above never cause an event in either mode.
- R5: With control = 2'b11, an event occurs when every channel that is set in either mask is at its selected level (high-mask channels high, low-mask channels low). Status then captures the input pattern ANDed with the armed set. With no channel armed, no event occurs.
- R6: After a level-mode event, no further event occurs until an armed input changes. A change on an unarmed input does not re-arm the logic. Writing a mask or the control register also re-arms it.
- R7: A read of the status register returns the captured pattern and clears both the status and the pending state. If no new event arrives, irq is low on the cycle after the read.
- R8: irq equals pending AND enable. While enable is 0, no event is recorded.
- R9: An input change that causes an event drives irq high after the third rising clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register; bits [1:0] are ignored |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe; a read of status clears it |
| rd_data | output | DATA_W (32) | Read data for bus_addr (combinational) |
| din | input | NUM_IN (32) | Raw digital inputs |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that wr_en and rd_en are never high together, and that the control register is not rewritten while an event is being checked. The bench drives each strobe alone for one cycle, and it disables the block and clears status before every reconfiguration. The bench holds the inputs steady for at least four cycles after each change, so that every synchronised change is evaluated before the next one. In level mode it arms at most three channels, so that the all-met condition occurs often under random patterns.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int NUM_IN  = 32,
  parameter int NUM_COS = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_IN-1:0] din,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_RAW  = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_HIGH = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_LOW  = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(4);

  logic [NUM_IN-1:0]  s1_q, s2_q, prev_q;
  logic [NUM_COS-1:0] high_q, low_q, stat_q;
  logic [1:0]         ctrl_q;
  logic               pend_q, hold_q;

  wire [WIDX_W-1:0]  widx  = bus_addr[ADDR_W-1:2];
  wire               en    = ctrl_q[0];
  wire               lvl   = ctrl_q[1];
  wire [NUM_COS-1:0] cur   = s2_q[NUM_COS-1:0];
  wire [NUM_COS-1:0] old   = prev_q[NUM_COS-1:0];
  wire [NUM_COS-1:0] armed = high_q | low_q;

  wire [NUM_COS-1:0] edge_hit  = (cur & ~old & high_q) | (~cur & old & low_q);
  wire               all_met   = (&((~high_q | cur) & (~low_q | ~cur))) && (|armed);
  wire               armed_chg = |((cur ^ old) & armed);
  wire               evt       = en && (lvl ? (all_met && !hold_q) : (|edge_hit));
  wire [NUM_COS-1:0] cap       = lvl ? (cur & armed) : edge_hit;

  wire cfg_wr  = wr_en && (widx == W_HIGH || widx == W_LOW || widx == W_CTRL);
  wire stat_rd = rd_en && (widx == W_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (widx == W_HIGH) high_q <= wr_data[NUM_COS-1:0];
      if (widx == W_LOW)  low_q  <= wr_data[NUM_COS-1:0];
      if (widx == W_CTRL) ctrl_q <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | (evt ? cap : '0);
      pend_q <= (pend_q && !stat_rd) || evt;
      if (cfg_wr)          hold_q <= 1'b0;
      else if (evt && lvl) hold_q <= 1'b1;
      else if (armed_chg)  hold_q <= 1'b0;
    end
  end

  always_comb begin
    case (widx)
      W_RAW:   rd_data = DATA_W'(s2_q);
      W_HIGH:  rd_data = DATA_W'(high_q);
      W_LOW:   rd_data = DATA_W'(low_q);
      W_STAT:  rd_data = DATA_W'(stat_q);
      W_CTRL:  rd_data = DATA_W'(ctrl_q);
      default: rd_data = '0;
    endcase
  end

  assign irq = pend_q && en;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int NUM_COS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stat_rd,
  input logic               evt,
  input logic               pend,
  input logic               hold,
  input logic [1:0]         ctrl,
  input logic [NUM_COS-1:0] cur,
  input logic [NUM_COS-1:0] old,
  input logic               irq
);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl[0]);

  a_r8_pending_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ctrl[0]));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt) |=> !pend);

  a_r6_held_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1] && hold) |-> !evt);

  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && evt) |-> (cur != old));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NUM_COS(NUM_COS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .evt(evt), .pend(pend_q),
  .hold(hold_q), .ctrl(ctrl_q), .cur(cur), .old(old), .irq(irq)
);

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [31:0] din = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_in = '0;
  logic [15:0] m_hi = '0, m_lo = '0, m_stat = '0;
  logic [1:0]  m_ctl = '0;
  logic        m_pend = 1'b0, m_hold = 1'b0;

  cos_irq_ctrl i_cos_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .din(din), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic lvl_met(input logic [15:0] v);
    logic [15:0] a = m_hi | m_lo;
    return (a != 0) && (((~m_hi | v) & (~m_lo | ~v)) == 16'hffff);
  endfunction

  task automatic eval_level_now();
    if (m_ctl == 2'b11 && lvl_met(m_in[15:0]) && !m_hold) begin
      m_pend = 1'b1; m_stat |= m_in[15:0] & (m_hi | m_lo); m_hold = 1'b1;
    end
  endtask

  task automatic set_in(input logic [31:0] nv);
    logic [15:0] o, n, armed;
    o = m_in[15:0]; n = nv[15:0]; armed = m_hi | m_lo;
    @(negedge clk);
    din = nv;
    repeat (4) @(negedge clk);
    if (m_ctl[0]) begin
      if (!m_ctl[1]) begin
        logic [15:0] hit;
        hit = (n & ~o & m_hi) | (~n & o & m_lo);
        if (hit != 0) begin m_pend = 1'b1; m_stat |= hit; end
      end else begin
        if (((o ^ n) & armed) != 0) m_hold = 1'b0;
        m_in = nv;
        eval_level_now();
      end
    end
    m_in = nv;
  endtask

  task automatic configure(input logic [1:0] c, input logic [15:0] hi, input logic [15:0] lo);
    logic [31:0] d;
    wr(8'h10, 32'h0);
    rd(8'h0C, d);
    m_stat = '0; m_pend = 1'b0;
    wr(8'h04, {16'hdead, hi});
    wr(8'h08, {16'hbeef, lo});
    wr(8'h10, {30'h0, c});
    m_hi = hi; m_lo = lo; m_ctl = c; m_hold = 1'b0;
    repeat (3) @(negedge clk);
    eval_level_now();
  endtask

  task automatic check_irq(input string req);
    check(req, {31'h0, irq}, {31'h0, m_pend & m_ctl[0]});
  endtask

  task automatic read_status(input string req);
    logic [31:0] d;
    rd(8'h0C, d);
    check(req, d, {16'h0, m_stat});
    m_stat = '0; m_pend = 1'b0;
    check("R7 irq low after read", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 high mask", d, 0);
    rd(8'h08, d); check("R1 low mask", d, 0);
    rd(8'h0C, d); check("R1 status", d, 0);
    check("R1 irq", {31'h0, irq}, 0);

    // R2 register map and synchroniser latency
    @(negedge clk); din = 32'hA5C3_0F1E;
    @(negedge clk); bus_addr = 8'h00;
    #1 check("R2 raw before two edges", rd_data, 32'h0);
    @(negedge clk); #1 check("R2 raw after two edges", rd_data, 32'hA5C3_0F1E);
    m_in = din;
    wr(8'h04, 32'hFFFF_1234); rd(8'h04, d); check("R2 high mask readback", d, 32'h1234);
    wr(8'h08, 32'hFFFF_8001); rd(8'h08, d); check("R2 low mask readback", d, 32'h8001);
    wr(8'h10, 32'hFFFF_FFFC); rd(8'h10, d); check("R2 ctrl readback", d, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); check("R2 status not writable", d, 32'h0);

    // R8 disabled: edges do nothing
    configure(2'b00, 16'hFFFF, 16'hFFFF);
    set_in(~m_in);
    check("R8 disabled no irq", {31'h0, irq}, 0);
    rd(8'h0C, d); check("R8 disabled status empty", d, 0);

    // R3 directed edges, R9 latency
    set_in(32'h0);
    configure(2'b01, 16'h0001, 16'h0002);
    @(negedge clk); din = 32'h0000_0003;
    @(negedge clk); @(negedge clk);
    check("R9 irq low after two edges", {31'h0, irq}, 0);
    @(negedge clk);
    check("R9 irq high after third edge", {31'h0, irq}, 1);
    m_in = din; m_pend = 1'b1; m_stat = 16'h0001;
    read_status("R3 rising on high channel");
    set_in(32'h0000_0001);
    check_irq("R3 falling on low channel");
    read_status("R3 status falling channel");

    // R4 upper channels ignored
    configure(2'b01, 16'hFFFF, 16'hFFFF);
    set_in(m_in ^ 32'hFFFF_0000);
    check("R4 upper edge no irq", {31'h0, irq}, 0);
    configure(2'b11, 16'h0000, 16'h0000);
    set_in(m_in ^ 32'hFFFF_0000);
    check("R5 none armed no irq", {31'h0, irq}, 0);

    // R5/R6 directed level
    set_in(32'h0);
    configure(2'b11, 16'h0005, 16'h0002);
    set_in(32'h0000_0001);
    check("R5 partial met no irq", {31'h0, irq}, 0);
    set_in(32'h0000_0005);
    check("R5 all met irq", {31'h0, irq}, 1);
    read_status("R5 level status");
    set_in(32'h0000_0005);
    check("R6 held no refire", {31'h0, irq}, 0);
    set_in(32'h0001_0105);
    check("R6 unarmed change no rearm", {31'h0, irq}, 0);
    set_in(32'h0001_0104);
    set_in(32'h0001_0105);
    check("R6 rearm after armed change", {31'h0, irq}, 1);
    read_status("R6 status after rearm");

    // random mix
    for (int t = 0; t < 300; t++) begin
      if (t % 30 == 0) begin
        if ($urandom_range(0, 1) == 0) begin
          configure(2'b01, 16'($urandom), 16'($urandom));
        end else begin
          logic [15:0] h, l;
          h = 16'(1 << $urandom_range(0, 15)) | 16'(1 << $urandom_range(0, 15));
          l = 16'(1 << $urandom_range(0, 15)) & ~h;
          configure(2'b11, h, l);
        end
      end
      set_in($urandom);
      check_irq(m_ctl[1] ? "R5 random level irq" : "R3 random edge irq");
      if ($urandom_range(0, 2) == 0) read_status("R7 random status");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule